// File: doc/BRIEF.md
# DSP Local-Memory Transfer Engine

This engine copies 16-bit words between a signal processor's two local memories (an instruction RAM and a data RAM) and a byte-addressed external main memory. Software first programs a main-memory byte address (split over two 16-bit registers), a DSP-side word address and a control word. The control word picks the local memory and the direction. Writing the byte count then starts the copy at once. The engine moves one word per cycle through plain synchronous read/write ports. It pipelines each read into a write on the following cycle.

Each request is screened before anything moves. A bad control value, an oversized count, an out-of-range data-RAM address or the unsupported instruction-RAM-to-main-memory direction is refused. A refused request sets a sticky error flag with a cause code and moves nothing. While a copy runs, a status bit in the control register reads as one. Further start requests are dropped until the copy ends.

Top module: `dsp_dma_engine`

## Requirements
- R1: The register port stores the control word at offset 0xC9, the byte count at 0xCB, the DSP word address at 0xCD (only the low DSP_AW bits are kept, read back zero-extended), the main-memory address bits 31:16 at 0xCE and bits 15:0 at 0xCF. Readback is combinational on `reg_rd_addr`; any other offset reads 0, and every register reads 0 after reset.
- R2: A write to offset 0xCB while idle, with a request that passes screening and a nonzero count, raises `busy` from the next cycle, and control bit 2 reads 1 for as long as `busy` is high.
- R3: Control bit 0 set copies local memory to main memory, clear copies main memory to local memory. Control bit 1 set selects instruction RAM, clear selects data RAM. The copy moves ceil(count/2) words. The DSP word address rises by 1 per word and wraps at 2^DSP_AW. The main-memory byte address rises by 2 per word, and at most one write strobe is active per cycle.
- R4: The first read is issued in the first cycle after the triggering edge, and one read follows per cycle. Each read's data is written to the destination in the following cycle.
- R5: After the cycle of the last write, `busy` is low, control bit 2 reads 0, and `done` is high for exactly one cycle.
- R6: A control value above 3 or a count above 0x4000 is refused with cause 1 and moves nothing; a count of exactly 0x4000 is accepted.
- R7: For data-RAM copies the main-memory address is masked with 0x7FFFFFFF (bit 31 ignored). If the masked address exceeds 0x01FFFFFF the request is refused with cause 2 and moves nothing.
- R8: For instruction-RAM loads from main memory the presented main-memory address is masked with 0x0FFFFFFF for every word.
- R9: A request with control value 3 (instruction RAM to main memory) is refused with cause 3 and moves nothing. Cause priority is 1, then 3, then 2.
- R10: A refusal sets `err_flag` and `err_cause`. Both hold through other register writes until the next accepted start request, which clears them to 0.
- R11: A write to offset 0xCB while `busy` is high is ignored: the stored count does not change and no extra word moves.
- R12: An accepted request with count 0 moves nothing, leaves `busy` low and pulses `done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write offset |
| reg_wdata | input | 16 | Register write data |
| reg_rd_addr | input | 8 | Register read offset |
| reg_rdata | output | 16 | Register read data |
| imem_rd_en | output | 1 | Instruction RAM read enable |
| imem_wr_en | output | 1 | Instruction RAM write enable |
| imem_addr | output | DSP_AW | Instruction RAM word address |
| imem_wdata | output | 16 | Instruction RAM write data |
| imem_rdata | input | 16 | Instruction RAM read data, one cycle after read |
| dmem_rd_en | output | 1 | Data RAM read enable |
| dmem_wr_en | output | 1 | Data RAM write enable |
| dmem_addr | output | DSP_AW | Data RAM word address |
| dmem_wdata | output | 16 | Data RAM write data |
| dmem_rdata | input | 16 | Data RAM read data, one cycle after read |
| mm_rd_en | output | 1 | Main memory read enable |
| mm_wr_en | output | 1 | Main memory write enable |
| mm_addr | output | 32 | Main memory byte address |
| mm_wdata | output | 16 | Main memory write data |
| mm_rdata | input | 16 | Main memory read data, one cycle after read |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse after a copy ends |
| err_flag | output | 1 | Sticky refusal flag |
| err_cause | output | 2 | Refusal cause: 0 none, 1 control/count, 2 range, 3 unsupported |

## Verification
A start request can arrive in the very cycle in which the final write of the running copy happens. In that cycle the engine must both finish and refuse the new start. The bench provokes this by counting cycles from the trigger and rewriting the count register exactly in the last-write cycle. It then judges the result at the ports: `done` pulses once, the count reads back unchanged, and the scoreboard sees no write beyond the expected ones over the following cycles. It also chains a refusal directly into a zero-count start, so the clearing of the error and the immediate `done` pulse are observed together.

// File: rtl/dsp_dma_pkg.sv
// Shared constants and types for the DSP local-memory transfer engine.
// Assumes a 16-bit register port with 8-bit offsets.
package dsp_dma_pkg;

    localparam int REG_W = 16;

    localparam logic [7:0] OFS_CTRL = 8'hC9;
    localparam logic [7:0] OFS_LEN  = 8'hCB;
    localparam logic [7:0] OFS_DSPA = 8'hCD;
    localparam logic [7:0] OFS_MMHI = 8'hCE;
    localparam logic [7:0] OFS_MMLO = 8'hCF;

    localparam logic [31:0] DMEM_MASK = 32'h7FFF_FFFF;
    localparam logic [31:0] IMEM_MASK = 32'h0FFF_FFFF;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_PARAM = 2'd1,
        CAUSE_RANGE = 2'd2,
        CAUSE_UNSUP = 2'd3
    } cause_t;

endpackage

// File: rtl/dsp_dma_regs.sv
// Register bank of the transfer engine: control, byte count, DSP word
// address and the two halves of the main-memory address.
// Assumes one write per cycle; bit 2 of control is owned by the engine
// while a copy runs (set on start, cleared on finish).
module dsp_dma_regs
    import dsp_dma_pkg::*;
#(
    parameter int DSP_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [7:0]        rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              busy,
    input  logic              start,
    input  logic              finish,
    output logic [REG_W-1:0]  ctl_q,
    output logic [REG_W-1:0]  len_q,
    output logic [DSP_AW-1:0] dspa_q,
    output logic [31:0]       mm_q
);

    logic ctl_wr;
    logic stat_nxt;

    assign ctl_wr = wr_en && (wr_addr == OFS_CTRL);

    // Next value of the status bit: start sets, finish clears, idle writes load.
    always_comb begin
        if (start)
            stat_nxt = 1'b1;
        else if (finish)
            stat_nxt = 1'b0;
        else if (ctl_wr && !busy)
            stat_nxt = wr_data[2];
        else
            stat_nxt = ctl_q[2];
    end

    // Register storage; the count register is frozen while a copy runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            len_q  <= '0;
            dspa_q <= '0;
            mm_q   <= '0;
        end else begin
            ctl_q[2] <= stat_nxt;
            if (ctl_wr) begin
                ctl_q[REG_W-1:3] <= wr_data[REG_W-1:3];
                ctl_q[1:0]       <= wr_data[1:0];
            end
            if (wr_en && (wr_addr == OFS_LEN) && !busy)
                len_q <= wr_data;
            if (wr_en && (wr_addr == OFS_DSPA))
                dspa_q <= wr_data[DSP_AW-1:0];
            if (wr_en && (wr_addr == OFS_MMHI))
                mm_q[31:16] <= wr_data;
            if (wr_en && (wr_addr == OFS_MMLO))
                mm_q[15:0] <= wr_data;
        end
    end

    // Combinational readback; unmapped offsets return zero.
    always_comb begin
        case (rd_addr)
            OFS_CTRL: rd_data = ctl_q;
            OFS_LEN:  rd_data = len_q;
            OFS_DSPA: rd_data = REG_W'(dspa_q);
            OFS_MMHI: rd_data = mm_q[31:16];
            OFS_MMLO: rd_data = mm_q[15:0];
            default:  rd_data = '0;
        endcase
    end

    AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(len_q)) else $error("count changed during copy"); // R11

endmodule

// File: rtl/dsp_dma_screen.sv
// Request screening: checks a start request against the control value,
// count limit, direction support and data-RAM address range, derives the
// word count and the address mask, and keeps the sticky error record.
// Assumes trig is a single-cycle start request from an idle engine.
module dsp_dma_screen
    import dsp_dma_pkg::*;
#(
    parameter int          LEN_W      = 16,
    parameter logic [15:0] MAX_LEN    = 16'h4000,
    parameter logic [31:0] DRAM_LIMIT = 32'h01FF_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [REG_W-1:0] ctl,
    input  logic [LEN_W-1:0] len,
    input  logic [31:0]      mm_addr,
    output logic             accept,
    output logic             zero_len,
    output logic [LEN_W-1:0] units,
    output logic [31:0]      mask,
    output logic             err_flag,
    output logic [1:0]       err_cause
);

    cause_t     cause_c;
    logic       bad_param;
    logic       unsup;
    logic       out_of_range;
    logic [LEN_W:0] len_up;

    // Classify the request; parameter faults win over direction, then range.
    always_comb begin
        bad_param    = (ctl > REG_W'(3)) || (len > LEN_W'(MAX_LEN));
        unsup        = (ctl[1:0] == 2'b11);
        out_of_range = !ctl[1] && ((mm_addr & DMEM_MASK) > DRAM_LIMIT);
        if (bad_param)
            cause_c = CAUSE_PARAM;
        else if (unsup)
            cause_c = CAUSE_UNSUP;
        else if (out_of_range)
            cause_c = CAUSE_RANGE;
        else
            cause_c = CAUSE_NONE;
    end

    // Derived transfer shape: word count rounds an odd byte count up.
    always_comb begin
        accept   = (cause_c == CAUSE_NONE);
        zero_len = (len == '0);
        len_up   = {1'b0, len} + (LEN_W+1)'(1);
        units    = len_up[LEN_W:1];
        mask     = ctl[1] ? IMEM_MASK : DMEM_MASK;
    end

    // Sticky error record, replaced only by a start request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag  <= 1'b0;
            err_cause <= CAUSE_NONE;
        end else if (trig) begin
            err_flag  <= !accept;
            err_cause <= cause_c;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !(trig && accept)) |=> err_flag) else $error("error flag dropped"); // R10
    AST_CAUSE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (err_cause != CAUSE_NONE)) else $error("flag without cause"); // R10

endmodule

// File: rtl/dsp_dma_walker.sv
// Word sequencer: once started it issues one source read per cycle and
// writes each returned word to the destination one cycle later.
// Assumes synchronous memories with one cycle of read latency and a
// nonzero word count on start.
module dsp_dma_walker #(
    parameter int DSP_AW = 12,
    parameter int LEN_W  = 16,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              zero_start,
    input  logic              dir_to_main,
    input  logic              sel_imem,
    input  logic [DSP_AW-1:0] dsp_base,
    input  logic [31:0]       mm_base,
    input  logic [31:0]       mm_mask,
    input  logic [LEN_W-1:0]  units,
    output logic              imem_rd_en,
    output logic              imem_wr_en,
    output logic [DSP_AW-1:0] imem_addr,
    output logic [DW-1:0]     imem_wdata,
    input  logic [DW-1:0]     imem_rdata,
    output logic              dmem_rd_en,
    output logic              dmem_wr_en,
    output logic [DSP_AW-1:0] dmem_addr,
    output logic [DW-1:0]     dmem_wdata,
    input  logic [DW-1:0]     dmem_rdata,
    output logic              mm_rd_en,
    output logic              mm_wr_en,
    output logic [31:0]       mm_addr,
    output logic [DW-1:0]     mm_wdata,
    input  logic [DW-1:0]     mm_rdata,
    output logic              busy,
    output logic              done,
    output logic              last_wr
);

    logic              running;
    logic              wr_pend;
    logic              to_main;
    logic              use_imem;
    logic [DSP_AW-1:0] dsp_ptr;
    logic [DSP_AW-1:0] wr_dsp;
    logic [31:0]       mm_ptr;
    logic [31:0]       mask_q;
    logic [31:0]       wr_mm;
    logic [LEN_W-1:0]  left;
    logic              done_q;
    logic              rd_local;
    logic              rd_main;
    logic              wr_local;
    logic              wr_main;
    logic [DSP_AW-1:0] dsp_addr;

    // Read stage: latch the job on start, then step both pointers per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            to_main  <= 1'b0;
            use_imem <= 1'b0;
            dsp_ptr  <= '0;
            mm_ptr   <= '0;
            mask_q   <= '0;
            left     <= '0;
        end else if (start) begin
            running  <= 1'b1;
            to_main  <= dir_to_main;
            use_imem <= sel_imem;
            dsp_ptr  <= dsp_base;
            mm_ptr   <= mm_base;
            mask_q   <= mm_mask;
            left     <= units;
        end else if (running) begin
            dsp_ptr <= dsp_ptr + DSP_AW'(1);
            mm_ptr  <= mm_ptr + 32'd2;
            left    <= left - LEN_W'(1);
            if (left == LEN_W'(1))
                running <= 1'b0;
        end
    end

    // Write stage: carry the read addresses one cycle to meet the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pend <= 1'b0;
            wr_dsp  <= '0;
            wr_mm   <= '0;
            done_q  <= 1'b0;
        end else begin
            wr_pend <= running;
            wr_dsp  <= dsp_ptr;
            wr_mm   <= mm_ptr & mask_q;
            done_q  <= (wr_pend && !running) || zero_start;
        end
    end

    // Port steering by direction and selected local memory.
    always_comb begin
        rd_local   = running && to_main;
        rd_main    = running && !to_main;
        wr_local   = wr_pend && !to_main;
        wr_main    = wr_pend && to_main;
        dsp_addr   = to_main ? dsp_ptr : wr_dsp;
        imem_rd_en = rd_local && use_imem;
        dmem_rd_en = rd_local && !use_imem;
        imem_wr_en = wr_local && use_imem;
        dmem_wr_en = wr_local && !use_imem;
        imem_addr  = dsp_addr;
        dmem_addr  = dsp_addr;
        imem_wdata = mm_rdata;
        dmem_wdata = mm_rdata;
        mm_rd_en   = rd_main;
        mm_wr_en   = wr_main;
        mm_addr    = to_main ? wr_mm : (mm_ptr & mask_q);
        mm_wdata   = use_imem ? imem_rdata : dmem_rdata;
        busy       = running || wr_pend;
        done       = done_q;
        last_wr    = wr_pend && !running;
    end

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({imem_wr_en, dmem_wr_en, mm_wr_en}) <= 1) else $error("two write strobes"); // R3
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_wr_en || dmem_wr_en || mm_wr_en) |-> $past(imem_rd_en || dmem_rd_en || mm_rd_en))
        else $error("write without prior read"); // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("done while busy"); // R5
    AST_DMEM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ((mm_rd_en || mm_wr_en) && !use_imem) |-> !mm_addr[31]) else $error("bit 31 leaked"); // R7
    AST_IMEM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_rd_en && use_imem) |-> (mm_addr[31:28] == 4'h0)) else $error("high nibble leaked"); // R8

endmodule

// File: rtl/dsp_dma_engine.sv
// Top of the DSP local-memory transfer engine: register bank, request
// screening and word sequencer. A count write while idle is the trigger.
// Assumes the memories answer reads one cycle later.
module dsp_dma_engine
    import dsp_dma_pkg::*;
#(
    parameter int          DSP_AW     = 12,
    parameter logic [15:0] MAX_LEN    = 16'h4000,
    parameter logic [31:0] DRAM_LIMIT = 32'h01FF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    input  logic [7:0]        reg_rd_addr,
    output logic [15:0]       reg_rdata,
    output logic              imem_rd_en,
    output logic              imem_wr_en,
    output logic [DSP_AW-1:0] imem_addr,
    output logic [15:0]       imem_wdata,
    input  logic [15:0]       imem_rdata,
    output logic              dmem_rd_en,
    output logic              dmem_wr_en,
    output logic [DSP_AW-1:0] dmem_addr,
    output logic [15:0]       dmem_wdata,
    input  logic [15:0]       dmem_rdata,
    output logic              mm_rd_en,
    output logic              mm_wr_en,
    output logic [31:0]       mm_addr,
    output logic [15:0]       mm_wdata,
    input  logic [15:0]       mm_rdata,
    output logic              busy,
    output logic              done,
    output logic              err_flag,
    output logic [1:0]        err_cause
);

    localparam int LEN_W = REG_W;

    logic [REG_W-1:0]  ctl_q;
    logic [REG_W-1:0]  len_q;
    logic [DSP_AW-1:0] dspa_q;
    logic [31:0]       mm_q;
    logic              trig;
    logic              accept;
    logic              zero_len;
    logic [LEN_W-1:0]  units;
    logic [31:0]       mask;
    logic              start;
    logic              zero_start;
    logic              last_wr;

    // Start decode: a count write while idle, split by screening result.
    always_comb begin
        trig       = reg_wr_en && (reg_addr == OFS_LEN) && !busy;
        start      = trig && accept && !zero_len;
        zero_start = trig && accept && zero_len;
    end

    dsp_dma_regs #(.DSP_AW(DSP_AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .rd_addr (reg_rd_addr),
        .rd_data (reg_rdata),
        .busy    (busy),
        .start   (start),
        .finish  (last_wr),
        .ctl_q   (ctl_q),
        .len_q   (len_q),
        .dspa_q  (dspa_q),
        .mm_q    (mm_q)
    );

    dsp_dma_screen #(
        .LEN_W      (LEN_W),
        .MAX_LEN    (MAX_LEN),
        .DRAM_LIMIT (DRAM_LIMIT)
    ) u_screen (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .ctl       (ctl_q),
        .len       (reg_wdata),
        .mm_addr   (mm_q),
        .accept    (accept),
        .zero_len  (zero_len),
        .units     (units),
        .mask      (mask),
        .err_flag  (err_flag),
        .err_cause (err_cause)
    );

    dsp_dma_walker #(
        .DSP_AW (DSP_AW),
        .LEN_W  (LEN_W),
        .DW     (REG_W)
    ) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .zero_start  (zero_start),
        .dir_to_main (ctl_q[0]),
        .sel_imem    (ctl_q[1]),
        .dsp_base    (dspa_q),
        .mm_base     (mm_q),
        .mm_mask     (mask),
        .units       (units),
        .imem_rd_en  (imem_rd_en),
        .imem_wr_en  (imem_wr_en),
        .imem_addr   (imem_addr),
        .imem_wdata  (imem_wdata),
        .imem_rdata  (imem_rdata),
        .dmem_rd_en  (dmem_rd_en),
        .dmem_wr_en  (dmem_wr_en),
        .dmem_addr   (dmem_addr),
        .dmem_wdata  (dmem_wdata),
        .dmem_rdata  (dmem_rdata),
        .mm_rd_en    (mm_rd_en),
        .mm_wr_en    (mm_wr_en),
        .mm_addr     (mm_addr),
        .mm_wdata    (mm_wdata),
        .mm_rdata    (mm_rdata),
        .busy        (busy),
        .done        (done),
        .last_wr     (last_wr)
    );

    AST_STATUS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ctl_q[2]) else $error("status bit low during copy"); // R2
    AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !accept) |=> !busy) else $error("refused request started"); // R6
    AST_LEN_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && (reg_addr == OFS_LEN) && busy) |=> $stable(len_q)) else $error("retrigger stored"); // R11

endmodule

// File: tb/dsp_dma_engine_test.sv
`timescale 1ns/1ps
module dsp_dma_engine_test;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr_en;
    logic [7:0]    reg_addr;
    logic [15:0]   reg_wdata;
    logic [7:0]    reg_rd_addr;
    logic [15:0]   reg_rdata;
    logic          imem_rd_en, imem_wr_en, dmem_rd_en, dmem_wr_en, mm_rd_en, mm_wr_en;
    logic [AW-1:0] imem_addr, dmem_addr;
    logic [15:0]   imem_wdata, imem_rdata, dmem_wdata, dmem_rdata, mm_wdata, mm_rdata;
    logic [31:0]   mm_addr;
    logic          busy, done, err_flag;
    logic [1:0]    err_cause;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 0;
    string cur_req = "R3";

    typedef struct {
        logic [1:0]  tgt;   // 0 data RAM, 1 instruction RAM, 2 main memory
        logic [31:0] addr;
        logic [15:0] data;
    } item_t;
    item_t exp_q[$];

    always #4 clk = ~clk;

    dsp_dma_engine uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
        .imem_rd_en(imem_rd_en), .imem_wr_en(imem_wr_en), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata), .imem_rdata(imem_rdata),
        .dmem_rd_en(dmem_rd_en), .dmem_wr_en(dmem_wr_en), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .mm_rd_en(mm_rd_en), .mm_wr_en(mm_wr_en), .mm_addr(mm_addr),
        .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
        .busy(busy), .done(done), .err_flag(err_flag), .err_cause(err_cause)
    );

    function automatic logic [15:0] mm_pat(logic [31:0] a);
        return a[16:1] ^ {a[31:28], 12'h000} ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] dsp_pat(bit im, logic [AW-1:0] a);
        return 16'(a) ^ (im ? 16'hC3C3 : 16'h1E1E);
    endfunction

    // Memory responders with one cycle of read latency.
    always @(posedge clk) begin
        if (imem_rd_en) imem_rdata <= dsp_pat(1'b1, imem_addr);
        if (dmem_rd_en) dmem_rdata <= dsp_pat(1'b0, dmem_addr);
        if (mm_rd_en)   mm_rdata   <= mm_pat(mm_addr);
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic see_write(logic [1:0] tgt, logic [31:0] a, logic [15:0] d);
        item_t it;
        if (exp_q.size() == 0) begin
            chk(1'b0, {cur_req, " unexpected write"}, a, 32'hFFFF_FFFF);
        end else begin
            it = exp_q.pop_front();
            chk(it.tgt == tgt && it.addr == a, {cur_req, " write address"}, {tgt, a[29:0]}, {it.tgt, it.addr[29:0]});
            chk(it.data == d, {cur_req, " write data"}, 32'(d), 32'(it.data));
        end
    endtask

    // Monitor: pop and compare every write the design makes.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (imem_wr_en) see_write(2'd1, 32'(imem_addr), imem_wdata);
            if (dmem_wr_en) see_write(2'd0, 32'(dmem_addr), dmem_wdata);
            if (mm_wr_en)   see_write(2'd2, mm_addr, mm_wdata);
        end
    end

    task automatic drive_wr(logic [7:0] a, logic [15:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [15:0] e, string req);
        reg_rd_addr = a;
        #1;
        chk(reg_rdata == e, req, 32'(reg_rdata), 32'(e));
    endtask

    task automatic setup(logic [15:0] ctl, logic [15:0] dsp, logic [31:0] mm);
        drive_wr(8'hC9, ctl);
        drive_wr(8'hCD, dsp);
        drive_wr(8'hCE, mm[31:16]);
        drive_wr(8'hCF, mm[15:0]);
    endtask

    // Driver side of the scoreboard: push the writes the requirements predict.
    task automatic plan(logic [15:0] ctl, logic [15:0] dsp, logic [31:0] mm, logic [15:0] len);
        int unsigned n = (int'(len) + 1) / 2;
        logic [31:0] msk = ctl[1] ? 32'h0FFF_FFFF : 32'h7FFF_FFFF;
        for (int unsigned i = 0; i < n; i++) begin
            item_t it;
            logic [AW-1:0] da = AW'(dsp + 16'(i));
            logic [31:0]   ma = (mm + 32'(2 * i)) & msk;
            if (ctl[0]) begin
                it.tgt = 2'd2; it.addr = ma; it.data = dsp_pat(ctl[1], da);
            end else begin
                it.tgt = ctl[1] ? 2'd1 : 2'd0; it.addr = 32'(da); it.data = mm_pat(ma);
            end
            exp_q.push_back(it);
        end
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic xfer(logic [15:0] ctl, logic [15:0] dsp, logic [31:0] mm, logic [15:0] len, string req);
        cur_req = req;
        setup(ctl, dsp, mm);
        plan(ctl, dsp, mm, len);
        drive_wr(8'hCB, len);
        chk(busy == 1'b1, {req, " busy after start"}, 32'(busy), 32'd1);
        wait_idle();
        chk(exp_q.size() == 0, {req, " all words moved"}, exp_q.size(), 32'd0);
        chk(err_flag == 1'b0, {req, " no error"}, 32'(err_flag), 32'd0);
    endtask

    task automatic refuse(logic [15:0] ctl, logic [31:0] mm, logic [15:0] len, logic [1:0] cause, string req);
        cur_req = req;
        setup(ctl, 16'h0010, mm);
        drive_wr(8'hCB, len);
        chk(busy == 1'b0, {req, " refused stays idle"}, 32'(busy), 32'd0);
        chk(err_flag == 1'b1, {req, " error flag"}, 32'(err_flag), 32'd1);
        chk(err_cause == cause, {req, " error cause"}, 32'(err_cause), 32'(cause));
        repeat (4) @(negedge clk);
        chk(err_flag == 1'b1, "R10 flag holds", 32'(err_flag), 32'd1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all-requirements act=timeout exp=completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0; reg_rd_addr = '0;
        imem_rdata = '0; dmem_rdata = '0; mm_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and readback
        chk(busy == 0 && done == 0 && err_flag == 0, "R1 reset outputs", {busy, done, err_flag}, 0);
        rd(8'hC9, 16'h0000, "R1 control after reset");
        setup(16'h0002, 16'hF123, 32'hABCD_1234);
        rd(8'hC9, 16'h0002, "R1 control");
        rd(8'hCD, 16'h0123, "R1 dsp address");
        rd(8'hCE, 16'hABCD, "R1 main high");
        rd(8'hCF, 16'h1234, "R1 main low");
        rd(8'h10, 16'h0000, "R1 unmapped");

        // R2 R4 R5 cycle timing, 2 words main to data RAM
        cur_req = "R4";
        setup(16'h0000, 16'h0010, 32'h0000_2000);
        plan(16'h0000, 16'h0010, 32'h0000_2000, 16'd4);
        drive_wr(8'hCB, 16'd4);
        chk(busy == 1'b1, "R2 busy", 32'(busy), 32'd1);
        rd(8'hC9, 16'h0004, "R2 status bit set");
        chk(mm_rd_en == 1'b1 && mm_addr == 32'h2000, "R4 first read", mm_addr, 32'h2000);
        chk(dmem_wr_en == 1'b0, "R4 no write yet", 32'(dmem_wr_en), 32'd0);
        @(negedge clk);
        chk(dmem_wr_en == 1'b1, "R4 write follows", 32'(dmem_wr_en), 32'd1);
        @(negedge clk);
        chk(busy == 1'b1 && done == 1'b0, "R5 last write cycle", {busy, done}, 32'd2);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b1, "R5 done pulse", {busy, done}, 32'd1);
        rd(8'hC9, 16'h0000, "R5 status bit cleared");
        @(negedge clk);
        chk(done == 1'b0, "R5 done single", 32'(done), 32'd0);

        // R3 directions and odd count
        xfer(16'h0001, 16'h0020, 32'h0000_4000, 16'd6, "R3");
        xfer(16'h0000, 16'h00F0, 32'h0000_0100, 16'd5, "R3");
        // R8 instruction load with masked address
        xfer(16'h0002, 16'h0200, 32'hF000_0100, 16'd8, "R8");
        // R7 bit 31 dropped, limit edge accepted
        xfer(16'h0000, 16'h0300, 32'h8000_0040, 16'd4, "R7");
        xfer(16'h0001, 16'h0040, 32'h01FF_FFF0, 16'd4, "R7");

        // R6 R7 R9 refusals
        refuse(16'h0000, 32'h0200_0000, 16'd4, 2'd2, "R7");
        refuse(16'h0003, 32'h0000_0100, 16'd4, 2'd3, "R9");
        refuse(16'h0005, 32'h0000_0100, 16'd4, 2'd1, "R6");
        refuse(16'h0000, 32'h0000_0100, 16'h4001, 2'd1, "R6");
        refuse(16'h0003, 32'h0200_0000, 16'd4, 2'd3, "R9");

        // R10 R12 sticky through writes, then zero-count start clears it
        cur_req = "R12";
        setup(16'h0000, 16'h0000, 32'h0000_0100);
        chk(err_flag == 1'b1 && err_cause == 2'd3, "R10 held across writes", {err_flag, err_cause}, 32'h7);
        drive_wr(8'hCB, 16'd0);
        chk(done == 1'b1 && busy == 1'b0, "R12 immediate done", {done, busy}, 32'd2);
        chk(err_flag == 1'b0 && err_cause == 2'd0, "R10 cleared on accept", {err_flag, err_cause}, 32'd0);
        @(negedge clk);
        chk(done == 1'b0, "R12 single pulse", 32'(done), 32'd0);

        // R11 retrigger in the last write cycle
        cur_req = "R11";
        setup(16'h0000, 16'h0050, 32'h0000_0800);
        plan(16'h0000, 16'h0050, 32'h0000_0800, 16'd6);
        drive_wr(8'hCB, 16'd6);
        repeat (3) @(negedge clk);
        chk(dmem_wr_en == 1'b1 && busy == 1'b1, "R11 final write cycle", {dmem_wr_en, busy}, 32'd3);
        drive_wr(8'hCB, 16'd2);
        chk(busy == 1'b0 && done == 1'b1, "R11 finished, retrigger dropped", {busy, done}, 32'd1);
        rd(8'hCB, 16'd6, "R11 count unchanged");
        repeat (6) @(negedge clk);
        chk(busy == 1'b0 && exp_q.size() == 0, "R11 nothing extra", {busy, 31'(exp_q.size())}, 32'd0);

        // R6 maximum count accepted, DSP address wraps
        xfer(16'h0000, 16'h0000, 32'h0000_1000, 16'h4000, "R6");

        summary();
        $finish;
    end

endmodule